// File: doc/BRIEF.md
# Sampled Input Noise Filter

This block cleans up a slow external interrupt pin before it reaches interrupt logic. The raw pin is first brought into the clock domain through a two-flop synchronizer. The synchronized value is then sampled at a slow rate taken from an internal divider. A new level is accepted only after three samples in a row agree on it, so a short glitch is dropped.

A 2-bit rate select picks one of three sampling periods: 32, 64 or 128 clock cycles. Its zero code bypasses the filter, and the synchronized input is then taken as the filtered level on every cycle. Each change of the filtered level can raise a one-cycle event pulse. The event fires either for one chosen polarity or for both polarities.

After reset the filtered level is loaded from the synchronized pin, so a pin that is already high at reset does not produce an edge.

Top module: `pin_noise_filter`

## Requirements
- R1: The raw pin passes through two synchronizer flops. In bypass, a pin change made between clock edges appears on `level_o` after the third rising edge and not after the second.
- R2: With filtering enabled, `level_o` takes a new value only after three consecutive samples show that value. A pulse shorter than two sample periods leaves `level_o` and `event_o` unchanged.
- R3: The rate code sets the sample period: 01 gives 32 cycles, 10 gives 64 cycles and 11 gives 128 cycles. An accepted change shows on `level_o` no sooner than 2 periods and no later than 3 periods plus 4 cycles after the pin changes.
- R4: `event_o` is a single-cycle pulse. It is high exactly in the first cycle in which `level_o` shows a new value.
- R5: When `both_sel_i` is 0, an event is raised only on a change to the level given by `pol_sel_i` (1 = rising, 0 = falling).
- R6: When `both_sel_i` is 1, every change of `level_o` raises an event.
- R7: Rate code 00 bypasses the filter. `level_o` then follows the synchronized pin on every cycle, including a one-cycle pulse.
- R8: After reset, `level_o` settles to the pin level within 3 cycles and raises no event, even when the pin is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Raw asynchronous pin |
| rate_sel_i | input | 2 | Sample rate: 00 bypass, 01 /32, 10 /64, 11 /128 |
| pol_sel_i | input | 1 | Polarity used when single-edge: 1 rising, 0 falling |
| both_sel_i | input | 1 | 1 raises events on both edges |
| level_o | output | 1 | Filtered level |
| event_o | output | 1 | One-cycle edge event |

## Verification
In bypass, a one-clock pin pulse produces a rising and a falling change of the filtered level on adjacent cycles. This puts two event decisions back to back, so the edge detection of one cycle meets the level update of the next. The bench sends such a pulse with both edges enabled and expects two events. It repeats the pulse with each single polarity and expects exactly one event. A monitor also checks that every event cycle coincides with a changed `level_o`.

// File: rtl/pnf_pkg.sv
package pnf_pkg;
  typedef enum logic [1:0] {
    RATE_BYPASS = 2'b00,
    RATE_SLOW1  = 2'b01,
    RATE_SLOW2  = 2'b10,
    RATE_SLOW3  = 2'b11
  } rate_e;
endpackage

// File: rtl/pnf_sync.sv
module pnf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pnf_tick_gen.sv
module pnf_tick_gen
  import pnf_pkg::*;
#(
  parameter int BASE_LOG2 = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_sel_i,
  output logic       tick_o
);
  localparam int CNT_W = BASE_LOG2 + 2;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;

  // tick at the end of each period of the selected length
  always_comb begin
    unique case (rate_e'(rate_sel_i))
      RATE_SLOW1: tick_o = &cnt_q[BASE_LOG2-1:0];
      RATE_SLOW2: tick_o = &cnt_q[BASE_LOG2:0];
      RATE_SLOW3: tick_o = &cnt_q;
      default:    tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pnf_vote.sv
module pnf_vote #(
  parameter int AGREE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic warm_i,
  input  logic bypass_i,
  input  logic sample_i,
  input  logic din_i,
  output logic level_o,
  output logic change_o
);
  localparam int HW = AGREE - 1;

  logic [HW-1:0] hist_q;
  logic          level_q, level_d;
  logic          agree;

  assign agree = (hist_q == {HW{din_i}}) && (din_i != level_q);

  always_comb begin
    level_d = level_q;
    if (!warm_i || bypass_i)      level_d = din_i;
    else if (sample_i && agree)   level_d = din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hist_q  <= '0;
      level_q <= 1'b0;
    end else begin
      level_q <= level_d;
      if (!warm_i || bypass_i) hist_q <= {HW{din_i}};
      else if (sample_i)       hist_q <= {hist_q[HW-2:0], din_i};
    end

  assign level_o  = level_q;
  assign change_o = level_d != level_q;

  // R2: between samples the filtered level holds
  a_r2_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_i && !bypass_i && !sample_i) |=> $stable(level_q));
endmodule

// File: rtl/pin_noise_filter.sv
module pin_noise_filter
  import pnf_pkg::*;
#(
  parameter int BASE_LOG2   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int AGREE       = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] rate_sel_i,
  input  logic       pol_sel_i,
  input  logic       both_sel_i,
  output logic       level_o,
  output logic       event_o
);
  localparam int WARM   = SYNC_STAGES + 1;
  localparam int WARM_W = $clog2(WARM + 1);

  logic              sync_lvl, tick, bypass, change, lvl;
  logic [WARM_W-1:0] warm_cnt_q;
  logic              warm, event_q, new_lvl;

  pnf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync_lvl)
  );

  pnf_tick_gen #(.BASE_LOG2(BASE_LOG2)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_sel_i(rate_sel_i), .tick_o(tick)
  );

  assign bypass = rate_e'(rate_sel_i) == RATE_BYPASS;

  // level is seeded from the synchronizer until it holds the pin
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    warm_cnt_q <= '0;
    else if (!warm) warm_cnt_q <= warm_cnt_q + 1'b1;

  assign warm = warm_cnt_q == WARM_W'(WARM);

  pnf_vote #(.AGREE(AGREE)) u_vote (
    .clk_i(clk_i), .rst_ni(rst_ni), .warm_i(warm), .bypass_i(bypass),
    .sample_i(tick), .din_i(sync_lvl), .level_o(lvl), .change_o(change)
  );

  assign new_lvl = ~lvl;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) event_q <= 1'b0;
    else         event_q <= warm && change && (both_sel_i || (new_lvl == pol_sel_i));

  assign level_o = lvl;
  assign event_o = event_q;

  // R4: an event only accompanies a fresh level
  a_r4_event_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_q |-> (lvl != $past(lvl)));
  // R5: single-edge events carry the chosen polarity
  a_r5_single_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_q && !$past(both_sel_i)) |-> (lvl == $past(pol_sel_i)));
  // R7: bypass follows the synchronized pin
  a_r7_bypass_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && bypass) |=> (lvl == $past(sync_lvl)));
  // R8: no event during the seeding window
  a_r8_quiet_warmup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warm |=> !event_q);
endmodule

// File: tb/pin_noise_filter_bench.sv
module pin_noise_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic [1:0] rate = 2'b00;
  logic       pol = 1'b1;
  logic       both = 1'b1;
  logic       lvl, ev;

  int total = 0, bad = 0, cyc = 0;
  int evt_cnt = 0, ev_mismatch = 0;
  logic prev_lvl = 1'b0;

  always #10 clk = ~clk;

  pin_noise_filter u_pin_noise_filter (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .rate_sel_i(rate),
    .pol_sel_i(pol), .both_sel_i(both), .level_o(lvl), .event_o(ev)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (ev) begin
        evt_cnt++;
        if (lvl == prev_lvl) ev_mismatch++;
      end
    end
    prev_lvl = lvl;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset(input logic p);
    int e0;
    rst_n = 1'b0; pin = p; rate = 2'b00;
    wait_cyc(3);
    evt_cnt = 0;
    rst_n = 1'b1;
    e0 = evt_cnt;
    wait_cyc(10);
    chk(lvl == p, "R8 level after reset", lvl, p);
    chk(evt_cnt == e0, "R8 no event after reset", evt_cnt - e0, 0);
  endtask

  task automatic t_bypass_latency;
    logic old;
    rate = 2'b00; both = 1'b1;
    wait_cyc(4);
    old = lvl;
    pin = ~old;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(lvl == old, "R1 not before third edge", lvl, old);
    @(posedge clk);
    @(negedge clk);
    chk(lvl == ~old, "R1 after third edge", lvl, ~old);
    wait_cyc(4);
  endtask

  task automatic t_glitch(input logic b, input logic p, input int exp_ev);
    int e0;
    rate = 2'b00; pin = 1'b0; both = b; pol = p;
    wait_cyc(6);
    e0 = evt_cnt;
    pin = 1'b1;
    @(negedge clk);
    pin = 1'b0;
    wait_cyc(6);
    chk(evt_cnt - e0 == exp_ev, b ? "R6/R7 bypass glitch events" : "R5/R7 bypass glitch events",
        evt_cnt - e0, exp_ev);
    chk(lvl == 1'b0, "R7 level back after glitch", lvl, 0);
  endtask

  task automatic t_rate(input logic [1:0] code);
    int per, e0;
    logic base;
    per = 32 << (code - 1);
    rate = code; both = 1'b1;
    wait_cyc(4 * per);
    base = lvl;
    pin = base;
    wait_cyc(4 * per);
    e0 = evt_cnt;
    pin = ~base;
    wait_cyc(2 * per - 4);
    pin = base;
    wait_cyc(4 * per);
    chk(lvl == base, "R2 short pulse rejected", lvl, base);
    chk(evt_cnt == e0, "R2 no event on short pulse", evt_cnt - e0, 0);
    pin = ~base;
    wait_cyc(2 * per);
    chk(lvl == base, "R3 not before two periods", lvl, base);
    wait_cyc(per + 4);
    chk(lvl == ~base, "R3 accepted within three periods", lvl, ~base);
    chk(evt_cnt - e0 == 1, "R4 one event per change", evt_cnt - e0, 1);
    pin = base;
    wait_cyc(3 * per + 4);
    chk(lvl == base, "R2 restored level", lvl, base);
  endtask

  task automatic t_polarity;
    int e0;
    rate = 2'b01; both = 1'b0; pol = 1'b0; pin = 1'b0;
    wait_cyc(200);
    e0 = evt_cnt;
    pin = 1'b1;
    wait_cyc(200);
    chk(lvl == 1'b1 && evt_cnt == e0, "R5 rising ignored when falling chosen", evt_cnt - e0, 0);
    pin = 1'b0;
    wait_cyc(200);
    chk(evt_cnt - e0 == 1, "R5 falling reported", evt_cnt - e0, 1);
    pol = 1'b1;
    pin = 1'b1;
    wait_cyc(200);
    chk(evt_cnt - e0 == 2, "R5 rising reported", evt_cnt - e0, 2);
  endtask

  initial begin
    t_reset(1'b1);
    t_reset(1'b0);
    t_bypass_latency();
    t_glitch(1'b1, 1'b1, 2);
    t_glitch(1'b0, 1'b1, 1);
    t_glitch(1'b0, 1'b0, 1);
    t_rate(2'b01);
    t_rate(2'b10);
    t_rate(2'b11);
    t_polarity();
    chk(ev_mismatch == 0, "R4 event aligned with level change", ev_mismatch, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule